// File: doc/BRIEF.md
# Two-level branch direction predictor

This block guesses whether a conditional branch will be taken and checks that guess against the next pc that fetch chose. The direction state is a set of 2-bit saturating counters. The counters are split into banks, and the current global history value picks the bank. Inside a bank, the entry is picked by low pc bits above the byte offset. The history register holds the outcomes of the most recent resolved branches.

The lookup port is combinational and is meant for the decode stage. Decode presents the pc, a branch flag, the branch offset and the next pc that fetch predicted. The block returns the predicted direction and the next pc that follows from it: pc plus the sign-extended offset when taken, or pc+4 when not taken. It also raises a redirect flag when a branch's computed next pc differs from the one fetch supplied.

The update port receives every resolved branch, whether or not it was mispredicted. Each update trains one counter, chosen by the history value before the shift, and then shifts the outcome into the history register.

Top module: `bdp_top`

## Requirements
- R1: After reset, every counter holds weakly not-taken (01) and the history is 0. A lookup at any pc then predicts not-taken with next pc = pc+4.
- R2: An update with taken=1 increments the selected counter, and the counter stays at 11 when already there.
- R3: An update with taken=0 decrements the selected counter, and the counter stays at 00 when already there.
- R4: The predicted direction is bit 1 of the selected counter. From a strong state it flips only after two consecutive opposite outcomes.
- R5: The entry index is pc[IDX_W+1:2]. Pc bits 1:0 and bits above IDX_W+1 do not affect which counter is read or trained.
- R6: The history is HIST_W bits wide (default 2). Each update shifts its outcome into bit 0 and drops the oldest bit. The history value selects one of 2^HIST_W banks, for lookup and for training alike. Training uses the history value from before the shift.
- R7: When the prediction is taken, lk_next_pc_o equals pc plus the OFF_W-bit offset sign-extended to XLEN. Otherwise it equals pc+4.
- R8: lk_redirect_o is 1 exactly when lk_is_br_i is 1 and lk_next_pc_o differs from lk_ppc_i. It is never 1 for a non-branch.
- R9: When a lookup and an update address the same entry in the same cycle, the lookup returns the counter value from before the update.
- R10: While up_valid_i is 0, no counter and no history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_pc_i | input | XLEN | Pc of the instruction in decode |
| lk_is_br_i | input | 1 | The instruction is a conditional branch |
| lk_off_i | input | OFF_W | Branch offset, two's complement |
| lk_ppc_i | input | XLEN | Next pc predicted by fetch |
| lk_taken_o | output | 1 | Predicted direction |
| lk_next_pc_o | output | XLEN | Next pc implied by the predicted direction |
| lk_redirect_o | output | 1 | Fetch's next pc disagrees with the prediction |
| up_valid_i | input | 1 | A resolved branch is presented |
| up_pc_i | input | XLEN | Pc of the resolved branch |
| up_taken_i | input | 1 | Resolved outcome |

## Verification
The bench drives counters into both saturation limits. A design that wraps at a limit would predict the opposite direction after long runs of the same outcome. Sequences of alternating outcomes expose any history bit that shifts in the wrong order, or a training step that uses the history from after the shift: either one trains a bank other than the one a later lookup reads. Pcs that differ only in their low two bits or in their upper bits must map to the same entry, so an index slice taken from the wrong bits shows up as a lost training result. A lookup that meets an update on the same entry must return the old value, and a negative offset must give a backward target. Either mistake changes the next pc or the redirect flag.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_RST = 2'b01;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'd1;
    else       return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bdp_ghr.sv
module bdp_ghr #(
  parameter int HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              taken_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)    hist_q <= '0;
        else if (upd_i) hist_q <= taken_i;
    end else begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)    hist_q <= '0;
        else if (upd_i) hist_q <= {hist_q[HIST_W-2:0], taken_i};
    end
  endgenerate

  assign hist_o = hist_q;
endmodule

// File: rtl/bdp_ctr_table.sv
module bdp_ctr_table
  import bdp_pkg::*;
#(
  parameter int HIST_W = 2,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIST_W-1:0] rd_bank_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output ctr_t              rd_ctr_o,
  input  logic              wr_en_i,
  input  logic [HIST_W-1:0] wr_bank_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_taken_i
);
  localparam int ADDR_W  = HIST_W + IDX_W;
  localparam int ENTRIES = 1 << ADDR_W;

  ctr_t              ctr_q [ENTRIES];
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;

  assign wr_addr = {wr_bank_i, wr_idx_i};
  assign rd_addr = {rd_bank_i, rd_idx_i};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)
        ctr_q[g] <= CTR_RST;
      else if (wr_en_i && (wr_addr == ADDR_W'(g)))
        ctr_q[g] <= ctr_step(ctr_q[g], wr_taken_i);
  end

  // registered state: a same-cycle write is not visible here
  assign rd_ctr_o = ctr_q[rd_addr];
endmodule

// File: rtl/bdp_target.sv
module bdp_target #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 13
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             taken_i,
  output logic [XLEN-1:0]  next_o
);
  logic [XLEN-1:0] off_sx;
  assign off_sx = {{(XLEN-OFF_W){off_i[OFF_W-1]}}, off_i};
  assign next_o = taken_i ? pc_i + off_sx : pc_i + XLEN'(4);
endmodule

// File: rtl/bdp_top.sv
module bdp_top
  import bdp_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 13,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [XLEN-1:0]  lk_pc_i,
  input  logic             lk_is_br_i,
  input  logic [OFF_W-1:0] lk_off_i,
  input  logic [XLEN-1:0]  lk_ppc_i,
  output logic             lk_taken_o,
  output logic [XLEN-1:0]  lk_next_pc_o,
  output logic             lk_redirect_o,
  input  logic             up_valid_i,
  input  logic [XLEN-1:0]  up_pc_i,
  input  logic             up_taken_i
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [HIST_W-1:0] hist;
  ctr_t              rd_ctr;
  logic              unused_pc_bits;

  assign unused_pc_bits = ^{lk_pc_i[IDX_LO-1:0], up_pc_i[IDX_LO-1:0],
                            up_pc_i[XLEN-1:IDX_HI+1]};

  bdp_ghr #(.HIST_W(HIST_W)) ghr_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (up_valid_i),
    .taken_i (up_taken_i),
    .hist_o  (hist)
  );

  // training indexes with the pre-shift history
  bdp_ctr_table #(.HIST_W(HIST_W), .IDX_W(IDX_W)) tbl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_bank_i  (hist),
    .rd_idx_i   (lk_pc_i[IDX_HI:IDX_LO]),
    .rd_ctr_o   (rd_ctr),
    .wr_en_i    (up_valid_i),
    .wr_bank_i  (hist),
    .wr_idx_i   (up_pc_i[IDX_HI:IDX_LO]),
    .wr_taken_i (up_taken_i)
  );

  assign lk_taken_o = rd_ctr[1];

  bdp_target #(.XLEN(XLEN), .OFF_W(OFF_W)) tgt_i (
    .pc_i    (lk_pc_i),
    .off_i   (lk_off_i),
    .taken_i (lk_taken_o),
    .next_o  (lk_next_pc_o)
  );

  assign lk_redirect_o = lk_is_br_i && (lk_next_pc_o != lk_ppc_i);
endmodule

// File: rtl/bdp_chk.sv
module bdp_chk #(
  parameter int XLEN   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_is_br_i,
  input logic [XLEN-1:0]   lk_ppc_i,
  input logic [XLEN-1:0]   lk_next_pc_o,
  input logic              lk_redirect_o,
  input logic              up_valid_i,
  input logic              up_taken_i,
  input logic [HIST_W-1:0] hist_i
);
  // R8
  nonbranch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_is_br_i |-> !lk_redirect_o);

  // R8
  redirect_differs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_redirect_o |-> (lk_next_pc_o != lk_ppc_i));

  // R8
  agree_no_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_is_br_i && !lk_redirect_o) |-> (lk_next_pc_o == lk_ppc_i));

  // R6
  hist_shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |=> (hist_i[0] == $past(up_taken_i)));

  // R10
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_valid_i |=> $stable(hist_i));
endmodule

bind bdp_top bdp_chk #(.XLEN(XLEN), .HIST_W(HIST_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lk_is_br_i    (lk_is_br_i),
  .lk_ppc_i      (lk_ppc_i),
  .lk_next_pc_o  (lk_next_pc_o),
  .lk_redirect_o (lk_redirect_o),
  .up_valid_i    (up_valid_i),
  .up_taken_i    (up_taken_i),
  .hist_i        (hist)
);

// File: tb/bdp_top_tb_top.sv
module bdp_top_tb_top;
  localparam int XLEN = 32, OFF_W = 13, IDX_W = 4, HIST_W = 2;
  localparam int NB = 1 << HIST_W, NE = 1 << IDX_W;

  logic             clk = 0, rst_n = 0;
  logic [XLEN-1:0]  lk_pc = '0, lk_ppc = '0, up_pc = '0;
  logic             lk_br = 0, up_v = 0, up_t = 0;
  logic [OFF_W-1:0] lk_off = '0;
  logic             taken_o, redir_o;
  logic [XLEN-1:0]  next_o;

  int n_chk = 0, n_fail = 0;
  int m_ctr [NB][NE];
  int m_hist = 0;

  always #10 clk = ~clk;

  bdp_top #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_pc_i(lk_pc), .lk_is_br_i(lk_br), .lk_off_i(lk_off), .lk_ppc_i(lk_ppc),
    .lk_taken_o(taken_o), .lk_next_pc_o(next_o), .lk_redirect_o(redir_o),
    .up_valid_i(up_v), .up_pc_i(up_pc), .up_taken_i(up_t)
  );

  task automatic check(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare, then advance the model
  task automatic cyc(string tag, logic [XLEN-1:0] pc, logic br, logic [OFF_W-1:0] off,
                     logic [XLEN-1:0] ppc, logic uv, logic [XLEN-1:0] upc, logic ut);
    int c, i;
    logic et, er;
    logic [XLEN-1:0] en;
    @(negedge clk);
    lk_pc = pc; lk_br = br; lk_off = off; lk_ppc = ppc;
    up_v = uv; up_pc = upc; up_t = ut;
    #1;
    c  = m_ctr[m_hist][pc[IDX_W+1:2]];
    et = (c >= 2);
    en = et ? pc + {{(XLEN-OFF_W){off[OFF_W-1]}}, off} : pc + 4;
    er = br && (en != ppc);
    check(tag, "taken", XLEN'(taken_o), XLEN'(et));
    check(tag, "next_pc", next_o, en);
    check(tag, "redirect", XLEN'(redir_o), XLEN'(er));
    if (uv) begin
      i = upc[IDX_W+1:2];
      if (ut) m_ctr[m_hist][i] = (m_ctr[m_hist][i] == 3) ? 3 : m_ctr[m_hist][i] + 1;
      else    m_ctr[m_hist][i] = (m_ctr[m_hist][i] == 0) ? 0 : m_ctr[m_hist][i] - 1;
      m_hist = ((m_hist << 1) | int'(ut)) & (NB - 1);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int e = 0; e < NE; e++) m_ctr[b][e] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state, every pc predicts not-taken
    for (int i = 0; i < NE; i++)
      cyc("R1", 32'(i * 4), 1, 13'd16, 32'(i * 4 + 4), 0, '0, 0);

    // R2: taken runs saturate high
    for (int i = 0; i < 8; i++)
      cyc("R2", 32'h100, 1, 13'd64, 32'h104, 1, 32'h100, 1);
    // R3: not-taken runs saturate low
    for (int i = 0; i < 8; i++)
      cyc("R3", 32'h100, 1, 13'd64, 32'h140, 1, 32'h100, 0);

    // R4: hysteresis with single and double flips
    for (int i = 0; i < 12; i++)
      cyc("R4", 32'h208, 1, 13'd32, 32'h20c, 1, 32'h208, (i % 3) != 2);

    // R5: aliasing pcs, low bits and high bits ignored
    for (int i = 0; i < 6; i++)
      cyc("R5", 32'h0000_0033, 1, 13'd8, 32'h37, 1, 32'hABC0_0030 | 32'(i << 12), 1);
    for (int i = 0; i < 4; i++)
      cyc("R5", 32'h7770_0032 + 32'(i << 8), 1, 13'd8, 32'h0, 0, '0, 0);

    // R6: history patterns select different banks
    for (int i = 0; i < 16; i++)
      cyc("R6", 32'h3c, 1, 13'd4, 32'h40, 1, 32'h3c, i[0] ^ i[2]);

    // R7: backward targets from taken-leaning counters
    for (int i = 0; i < 6; i++)
      cyc("R7", 32'h1010, 1, 13'h1ff0, 32'h1014, 1, 32'h1010, 1);
    for (int i = 0; i < 4; i++)
      cyc("R7", 32'h1010, 1, 13'h1000, 32'h1014, 0, '0, 0);

    // R8: matching ppc, mismatching ppc, non-branch
    cyc("R8", 32'h1010, 1, 13'h1000, 32'h0010, 0, '0, 0);
    cyc("R8", 32'h1010, 0, 13'h1000, 32'hdead_beef, 0, '0, 0);
    cyc("R8", 32'h0044, 0, 13'd4, 32'h0, 0, '0, 0);
    cyc("R8", 32'h0044, 1, 13'd4, 32'h48, 0, '0, 0);

    // R9: same-entry lookup and update in one cycle
    for (int i = 0; i < 8; i++)
      cyc("R9", 32'h2c, 1, 13'd12, 32'h30, 1, 32'h2c, i < 4);

    // R10: update inputs toggled while up_valid_i is low
    for (int i = 0; i < 8; i++)
      cyc("R10", 32'h2c, 1, 13'd12, 32'h30, 0, 32'h2c, i[0]);

    // R6: mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [XLEN-1:0] p;
      p = 32'($urandom_range(0, 255)) << 2;
      cyc("R6", p, 1'($urandom), 13'($urandom), ($urandom_range(0, 1) == 1) ? p + 4 : 32'($urandom),
          1'($urandom), 32'($urandom_range(0, 63)) << 2, 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule